// File: doc/BRIEF.md
# Receive Buffer Throttle Controller with Hysteresis

This block watches how full the receive buffer of a serial port is and decides when the far-end transmitter must pause and when it may continue. It reads one 8-bit threshold byte that holds two 4-bit fields. The low field sets the stop level and the high field sets the restart level. Each field is scaled by four, so either level can be 0 to 60 entries. Because the two levels are separate, the block has hysteresis. Once the far end has been told to stop, it is not told to restart until the buffer has drained down to the lower level.

The block can throttle the far end in one of two ways. In hardware mode it drives an active-low request-to-send line: 0 means keep sending and 1 means pause. In software mode it issues one-cycle requests asking the local transmitter to send a stop character or a restart character. The block remembers whether the far end is currently stopped and shows this on a status output.

The buffer, the character transmitter and the register bus decode are outside the block. The buffer fill count arrives as a plain input.

Top module: `rx_flow_throttle`

## Requirements
- R1: After reset: `rts_n` is 0, `halted` is 0, neither `xoff_req` nor `xon_req` is asserted, and `cfg_rdata` reads 8'h4C.
- R2: A write with `cfg_wr`=1 stores `cfg_wdata` at the clock edge, and `cfg_rdata` returns the stored byte from the next cycle on.
- R3: The stop level is `cfg[3:0]*4`. When enabled and `rx_count` is greater than or equal to the stop level at a clock edge, `halted` is 1 after that edge. In hardware mode (`fc_sw`=0), `rts_n` then reads 1.
- R4: The restart level is `cfg[7:4]*4`. When enabled, `halted` is 1, and `rx_count` is at or below the restart level and below the stop level at an edge, `halted` is 0 after that edge. In hardware mode, `rts_n` then reads 0.
- R5: When enabled and `rx_count` is strictly between the restart level and the stop level, `halted` keeps its value.
- R6: In software mode (`fc_sw`=1), `rts_n` stays 0. `xoff_req` is high for exactly one cycle, in the cycle after each change of `halted` from 0 to 1.
- R7: In software mode, `xon_req` is high for exactly one cycle, in the cycle after each change of `halted` from 1 to 0. No request of either kind is issued in hardware mode.
- R8: `xoff_req` and `xon_req` are never high together. Neither one repeats while `halted` stays unchanged.
- R9: When the stop level is at or below the restart level, the stop condition wins. `halted` stays 1 for as long as `rx_count` meets the stop level.
- R10: When `fc_en` is 0, `rts_n` reads 0 at once. From the next edge on, `halted` is 0 and no request is issued, including no `xon_req` for the forced exit from the stopped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the threshold byte |
| cfg_wdata | input | 8 | Threshold byte to write: [3:0] stop level/4, [7:4] restart level/4 |
| cfg_rdata | output | 8 | Stored threshold byte |
| fc_en | input | 1 | Throttling enable |
| fc_sw | input | 1 | 1 selects software (character) mode, 0 selects hardware (line) mode |
| rx_count | input | 7 | Receive buffer fill count, 0 to 64 |
| rts_n | output | 1 | Active-low request-to-send: 0 lets the far end send, 1 pauses it |
| xoff_req | output | 1 | One-cycle request to send the stop character |
| xon_req | output | 1 | One-cycle request to send the restart character |
| halted | output | 1 | Far end is currently throttled |

## Verification
Every one of the 256 threshold bytes is loaded in turn. For each one, the fill count is ramped from 0 to 64 and back to 0, first in hardware mode and then in software mode.

- The rising ramp finds the exact count at which the block stops the far end.
- The falling ramp finds the exact count at which it restarts. A design without hysteresis, or one that mixes up the two fields, gives different edges from these.
- Threshold bytes whose stop level is at or below the restart level show whether the stop condition keeps priority.
- Repeating the ramps in software mode separates the one-shot character requests from level-style outputs.
- Turning the block off while it is stopped checks the silent forced exit.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

  typedef enum logic {
    FC_RUN  = 1'b0,
    FC_HALT = 1'b1
  } fc_state_e;

  typedef struct packed {
    logic xoff;
    logic xon;
  } fc_req_t;

endpackage

// File: rtl/rxfc_cfg_reg.sv
module rxfc_cfg_reg #(
  parameter int          CFG_W   = 8,
  parameter logic [CFG_W-1:0] RST_VAL = 8'h4C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= wdata;
  end

endmodule

// File: rtl/rxfc_thresh.sv
module rxfc_thresh #(
  parameter int NIB_W = 4,
  parameter int SHIFT = 2,
  parameter int OCC_W = 7
) (
  input  logic [2*NIB_W-1:0] cfg,
  input  logic [OCC_W-1:0]   occ,
  output logic               at_halt,
  output logic               at_resume
);

  localparam int NFIELD = 2;

  logic [OCC_W-1:0] thr [NFIELD];

  // field 0 = stop level, field 1 = restart level
  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    assign thr[i] = {{(OCC_W-NIB_W){1'b0}}, cfg[i*NIB_W +: NIB_W]} << SHIFT;
  end

  assign at_halt   = (occ >= thr[0]);
  assign at_resume = (occ <= thr[1]);

endmodule

// File: rtl/rxfc_fsm.sv
module rxfc_fsm
  import rxfc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    sw,
  input  logic    at_halt,
  input  logic    at_resume,
  output logic    halted,
  output fc_req_t req
);

  fc_state_e st, nxt;

  // stop condition is tested first, so it wins when both levels are met
  always_comb begin
    nxt = st;
    if (!en)                          nxt = FC_RUN;
    else if (at_halt)                 nxt = FC_HALT;
    else if (st == FC_HALT && at_resume) nxt = FC_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= FC_RUN;
      req.xoff <= 1'b0;
      req.xon  <= 1'b0;
    end else begin
      st       <= nxt;
      req.xoff <= en && sw && (st == FC_RUN)  && (nxt == FC_HALT);
      req.xon  <= en && sw && (st == FC_HALT) && (nxt == FC_RUN);
    end
  end

  assign halted = (st == FC_HALT);

  a_r3_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (en && at_halt) |=> halted);
  a_r4_resume_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (en && halted && at_resume && !at_halt) |=> !halted);
  a_r5_hold_band: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !at_halt && !at_resume) |=> $stable(halted));
  a_r6_xoff_single: assert property (@(posedge clk) disable iff (!rst_n)
    req.xoff |=> !req.xoff);
  a_r7_xon_single: assert property (@(posedge clk) disable iff (!rst_n)
    req.xon |=> !req.xon);
  a_r8_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(req.xon && req.xoff));
  a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!halted && !req.xon && !req.xoff));

endmodule

// File: rtl/rx_flow_throttle.sv
module rx_flow_throttle
  import rxfc_pkg::*;
#(
  parameter int         FIFO_DEPTH = 64,
  parameter int         NIB_W      = 4,
  parameter int         SHIFT      = 2,
  parameter logic [7:0] CFG_RST    = 8'h4C,
  localparam int        CFG_W      = 2*NIB_W,
  localparam int        OCC_W      = $clog2(FIFO_DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             fc_en,
  input  logic             fc_sw,
  input  logic [OCC_W-1:0] rx_count,
  output logic             rts_n,
  output logic             xoff_req,
  output logic             xon_req,
  output logic             halted
);

  logic    at_halt, at_resume;
  fc_req_t req;

  rxfc_cfg_reg #(.CFG_W(CFG_W), .RST_VAL(CFG_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(cfg_wdata), .q(cfg_rdata)
  );

  rxfc_thresh #(.NIB_W(NIB_W), .SHIFT(SHIFT), .OCC_W(OCC_W)) u_thr (
    .cfg(cfg_rdata), .occ(rx_count), .at_halt(at_halt), .at_resume(at_resume)
  );

  rxfc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(fc_en), .sw(fc_sw),
    .at_halt(at_halt), .at_resume(at_resume), .halted(halted), .req(req)
  );

  assign rts_n    = halted && fc_en && !fc_sw;
  assign xoff_req = req.xoff;
  assign xon_req  = req.xon;

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_rdata == $past(cfg_wdata)));
  a_r6_sw_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    fc_sw |-> !rts_n);
  a_r7_hw_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (!fc_sw && $past(!fc_sw)) |-> (!xon_req && !xoff_req));

endmodule

// File: tb/tb_rx_flow_throttle.sv
module tb_rx_flow_throttle;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       fc_en = 1'b0, fc_sw = 1'b0;
  logic [6:0] rx_count = '0;
  logic       rts_n, xoff_req, xon_req, halted;

  int n_run = 0, n_fail = 0;
  bit m_st = 1'b0;   // expected stopped state
  int hl = 0, rl = 0;

  always #10 clk = ~clk;

  rx_flow_throttle dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .fc_en(fc_en), .fc_sw(fc_sw), .rx_count(rx_count),
    .rts_n(rts_n), .xoff_req(xoff_req), .xon_req(xon_req), .halted(halted)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cfg=%02h occ=%0d en=%0d sw=%0d)",
               tag, act, exp, cfg_rdata, rx_count, fc_en, fc_sw);
    end
  endtask

  // drive at negedge, step one edge, check at the following negedge
  task automatic step(input int occ, input bit en, input bit sw);
    bit nst, exoff, exon;
    string tg;
    rx_count = 7'(occ);
    fc_en = en;
    fc_sw = sw;
    if (!en)               begin nst = 1'b0;  tg = "R10"; end
    else if (occ >= hl)    begin nst = 1'b1;  tg = (hl <= rl) ? "R9" : "R3"; end
    else if (m_st && occ <= rl) begin nst = 1'b0; tg = "R4"; end
    else                   begin nst = m_st;  tg = "R5"; end
    exoff = en && sw && !m_st && nst;
    exon  = en && sw && m_st && !nst;
    @(posedge clk);
    @(negedge clk);
    chk({tg, " halted"}, halted, nst);
    chk(sw ? "R6 rts_n" : {tg, " rts_n"}, rts_n, en && !sw && nst);
    chk(sw ? "R6 xoff_req" : "R7 R8 xoff_req", xoff_req, exoff);
    chk(sw ? "R7 xon_req" : "R7 R8 xon_req", xon_req, exon);
    m_st = nst;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rts_n", rts_n, 0);
    chk("R1 halted", halted, 0);
    chk("R1 xoff_req", xoff_req, 0);
    chk("R1 xon_req", xon_req, 0);
    chk("R1 cfg_rdata", cfg_rdata, 8'h4C);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 256; c++) begin
      cfg_wr = 1'b1;
      cfg_wdata = 8'(c);
      @(posedge clk);
      @(negedge clk);
      cfg_wr = 1'b0;
      chk("R2 readback", cfg_rdata, c);
      hl = (c % 16) * 4;
      rl = (c / 16) * 4;
      for (int s = 0; s < 2; s++) begin
        for (int o = 0; o <= 64; o++) step(o, 1'b1, s[0]);
        for (int o = 64; o >= 0; o--) step(o, 1'b1, s[0]);
      end
      // forced exit while stopped: R10
      step(64, 1'b1, c[0]);
      step(64, 1'b0, c[0]);
      chk("R10 rts_n off", rts_n, 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule